// File: doc/BRIEF.md
# Zero-Turnaround Late-Write Synchronous SRAM

This block models a pipelined synchronous SRAM that takes one command on every rising clock edge. Its inputs and outputs are both registered. A read returns its word one cycle after the command. A write takes its data two cycles after the command. Because of these timings, reads and writes can alternate with no idle cycles between them, and the data bus never needs a turnaround gap.

A command either loads a fresh address or continues the current burst. A continue cycle steps the two low address bits through four beats, in linear order or in XOR order, and the upper address bits stay fixed. Two enables have a programmable sense and together select the bank. A third enable, active low, selects within the bank. The data output enable and the echo-clock output enable follow separate deselect rules. A read that hits a write whose data arrives at the same edge gets the merged word.

The array is a small parameterised RAM with 256 words of four 9-bit lanes by default. It is meant to sit behind a memory controller that already uses this late-write command timing.

Top module: `lateWriteSram`

## Requirements
- R1: While reset is asserted and on the first edge after it is released, `dataOe` and `echoOe` are low. The block leaves reset bank-deselected.
- R2: A command loads only when `burstStep` is low. `writeN`, `chipEnN` and `laneWrN` are sampled only on load cycles. When `burstStep` is high, the previous operation type continues whatever those pins carry.
- R3: A read loaded at edge n drives the array word at its address on `dataOut`, with `dataOe` high, from edge n+1 until edge n+2.
- R4: A write loaded at edge n samples its address and lane mask at edge n. It stores `dataIn` as sampled at edge n+2.
- R5: The bank is selected only when `bankSelA == bankSelAHigh` and `bankSelB == bankSelBHigh`. A load without bank select is a bank deselect. A load with bank select and `chipEnN` high is a plain deselect.
- R6: Lane k is `dataIn`/`dataOut` bits [9k+8:9k], and `laneWrN[k]` low enables it. A write with all four bits high is an abort: its address is loaded and nothing is stored.
- R7: Each continue after a read or write load advances the beat count by one, and only the two low address bits change. The fourth continue returns to the base address.
- R8: With `xorOrder` high, the low bits are base XOR count. With `xorOrder` low, they are (base + count) mod 4.
- R9: After a write, deselect or bank-deselect command at edge n, `dataOe` is low from edge n+1.
- R10: After a bank deselect at edge n, `echoOe` is low from edge n+1. After a read, write or plain deselect it is high.
- R11: A read loaded the cycle after a write to the same address returns that write's enabled lanes, taken from `dataIn` at the read's output edge, merged over the stored word.
- R12: A continue while deselected or bank-deselected keeps that state: nothing is read or stored, and the output enables do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Word address, sampled on loads |
| burstStep | input | 1 | 0 = load a new command, 1 = continue |
| chipEnN | input | 1 | In-bank enable, active low, load cycles only |
| bankSelA | input | 1 | First programmable-sense bank enable |
| bankSelB | input | 1 | Second programmable-sense bank enable |
| bankSelAHigh | input | 1 | Static level that makes `bankSelA` true |
| bankSelBHigh | input | 1 | Static level that makes `bankSelB` true |
| writeN | input | 1 | 0 = write, 1 = read, load cycles only |
| laneWrN | input | LANES | Lane write enables, active low |
| xorOrder | input | 1 | Static burst order: 1 XOR, 0 linear |
| dataIn | input | LANES*LANE_W | Write data, two cycles after its command |
| dataOut | output | LANES*LANE_W | Registered read data |
| dataOe | output | 1 | Drive enable for `dataOut` |
| echoOe | output | 1 | Drive enable for the echo clock |

## Verification
The bench targets several corner cases, and each one fails in a recognisable way when the design gets it wrong.

- Back-to-back write-then-read to the same address. A design without forwarding returns the stale word.
- Bursts that start at a nonzero low address in both orders and run a fifth beat. A carry into the upper bits, or a missing wrap, reads the wrong word.
- Aborts, single-lane writes, and write or read pins toggled during continues. Any of these would corrupt stored lanes if the pins were honoured outside load cycles.
- Deselects by each route. A design that drops the echo enable on an in-bank deselect, or that leaves a deselected continue active, shows it on `echoOe` or on the data read back afterwards.

// File: rtl/lateWriteSramPkg.sv
package lateWriteSramPkg;

  typedef enum logic [1:0] {
    OP_BANK_OFF = 2'd0,
    OP_IDLE     = 2'd1,
    OP_READ     = 2'd2,
    OP_WRITE    = 2'd3
  } cmdOp_e;

  // strobes from control to datapath, valid for the coming edge
  typedef struct packed {
    logic readEn;
    logic commitEn;
    logic dataOeNext;
    logic echoOeNext;
  } ctrlStrobes_t;

endpackage

// File: rtl/burstAddrGen.sv
module burstAddrGen #(
  parameter int STEP_W = 2
) (
  input  logic [STEP_W-1:0] baseLow,
  input  logic [STEP_W-1:0] step,
  input  logic              xorOrder,
  output logic [STEP_W-1:0] nextLow
);

  always_comb begin
    if (xorOrder) nextLow = baseLow ^ step;
    else          nextLow = baseLow + step;
  end

  // R8
  always_comb begin
    if (step != '0) begin
      step_moves_chk: assert (nextLow != baseLow);
    end
  end

endmodule

// File: rtl/cmdCtrl.sv
module cmdCtrl
  import lateWriteSramPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int STEP_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              burstStep,
  input  logic              chipEnN,
  input  logic              bankSelA,
  input  logic              bankSelB,
  input  logic              bankSelAHigh,
  input  logic              bankSelBHigh,
  input  logic              writeN,
  input  logic [LANES-1:0]  laneWrN,
  input  logic              xorOrder,
  output ctrlStrobes_t      strb,
  output logic [ADDR_W-1:0] readAddr,
  output logic [ADDR_W-1:0] commitAddr,
  output logic [LANES-1:0]  commitMask
);

  cmdOp_e             curOp, nextOp;
  logic [ADDR_W-1:0]  curAddr, baseAddr, wr2Addr;
  logic [STEP_W-1:0]  burstCnt, nextCnt, genLow;
  logic [LANES-1:0]   curMask, wr2Mask;
  logic               wr2Valid;
  logic               bankMatch, isXfer;

  assign bankMatch = (bankSelA == bankSelAHigh) && (bankSelB == bankSelBHigh);
  assign isXfer    = (curOp == OP_READ) || (curOp == OP_WRITE);
  assign nextCnt   = burstCnt + 1'b1;

  burstAddrGen #(.STEP_W(STEP_W)) u_burstAddrGen (
    .baseLow  (baseAddr[STEP_W-1:0]),
    .step     (nextCnt),
    .xorOrder (xorOrder),
    .nextLow  (genLow)
  );

  always_comb begin
    nextOp = curOp;
    if (!burstStep) begin
      if (!bankMatch)   nextOp = OP_BANK_OFF;
      else if (chipEnN) nextOp = OP_IDLE;
      else if (writeN)  nextOp = OP_READ;
      else              nextOp = OP_WRITE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curOp    <= OP_BANK_OFF;
      curAddr  <= '0;
      baseAddr <= '0;
      burstCnt <= '0;
      curMask  <= '0;
      wr2Valid <= 1'b0;
      wr2Addr  <= '0;
      wr2Mask  <= '0;
    end else begin
      curOp    <= nextOp;
      wr2Valid <= (curOp == OP_WRITE) && (|curMask);
      wr2Addr  <= curAddr;
      wr2Mask  <= curMask;
      if (!burstStep) begin
        baseAddr <= addr;
        curAddr  <= addr;
        burstCnt <= '0;
        curMask  <= ~laneWrN;
      end else if (isXfer) begin
        burstCnt <= nextCnt;
        curAddr  <= {baseAddr[ADDR_W-1:STEP_W], genLow};
      end
    end
  end

  assign strb.readEn     = (curOp == OP_READ);
  assign strb.commitEn   = wr2Valid;
  assign strb.dataOeNext = (curOp == OP_READ);
  assign strb.echoOeNext = (curOp != OP_BANK_OFF);
  assign readAddr        = curAddr;
  assign commitAddr      = wr2Addr;
  assign commitMask      = wr2Mask;

  // R2
  continue_keeps_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    burstStep |=> (curOp == $past(curOp)));

  // R7
  burst_upper_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (burstStep && isXfer) |=> (curAddr[ADDR_W-1:STEP_W] == $past(baseAddr[ADDR_W-1:STEP_W])));

  // R12
  idle_continue_chk: assert property (@(posedge clk) disable iff (!rstN)
    (burstStep && !isXfer) |=> $stable(curAddr));

endmodule

// File: rtl/sramDatapath.sv
module sramDatapath
  import lateWriteSramPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobes_t            strb,
  input  logic [ADDR_W-1:0]       readAddr,
  input  logic [ADDR_W-1:0]       commitAddr,
  input  logic [LANES-1:0]        commitMask,
  input  logic [LANES*LANE_W-1:0] dataIn,
  output logic [LANES*LANE_W-1:0] dataOut,
  output logic                    dataOe,
  output logic                    echoOe
);

  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] bitMask, arrWord, fwdWord, commitWord;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign bitMask[k*LANE_W +: LANE_W] = {LANE_W{commitMask[k]}};
  end

  assign commitWord = (mem[commitAddr] & ~bitMask) | (dataIn & bitMask);
  assign arrWord    = mem[readAddr];
  assign fwdWord    = (strb.commitEn && (commitAddr == readAddr))
                    ? ((arrWord & ~bitMask) | (dataIn & bitMask)) : arrWord;

  always_ff @(posedge clk) begin
    if (strb.commitEn) mem[commitAddr] <= commitWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut <= '0;
      dataOe  <= 1'b0;
      echoOe  <= 1'b0;
    end else begin
      dataOe <= strb.dataOeNext;
      echoOe <= strb.echoOeNext;
      if (strb.readEn) dataOut <= fwdWord;
    end
  end

  // R10
  oe_needs_echo_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> echoOe);

  // R6
  abort_no_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.commitEn |-> (|commitMask));

endmodule

// File: rtl/lateWriteSram.sv
module lateWriteSram
  import lateWriteSramPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    burstStep,
  input  logic                    chipEnN,
  input  logic                    bankSelA,
  input  logic                    bankSelB,
  input  logic                    bankSelAHigh,
  input  logic                    bankSelBHigh,
  input  logic                    writeN,
  input  logic [LANES-1:0]        laneWrN,
  input  logic                    xorOrder,
  input  logic [LANES*LANE_W-1:0] dataIn,
  output logic [LANES*LANE_W-1:0] dataOut,
  output logic                    dataOe,
  output logic                    echoOe
);

  ctrlStrobes_t      strb;
  logic [ADDR_W-1:0] readAddr, commitAddr;
  logic [LANES-1:0]  commitMask;
  logic              bankOn;

  cmdCtrl #(.ADDR_W(ADDR_W), .LANES(LANES), .STEP_W(2)) u_cmdCtrl (
    .clk, .rstN, .addr, .burstStep, .chipEnN, .bankSelA, .bankSelB,
    .bankSelAHigh, .bankSelBHigh, .writeN, .laneWrN, .xorOrder,
    .strb, .readAddr, .commitAddr, .commitMask
  );

  sramDatapath #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_sramDatapath (
    .clk, .rstN, .strb, .readAddr, .commitAddr, .commitMask, .dataIn,
    .dataOut, .dataOe, .echoOe
  );

  assign bankOn = (bankSelA == bankSelAHigh) && (bankSelB == bankSelBHigh);

  // R3
  read_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!burstStep && bankOn && !chipEnN && writeN) |=> ##1 dataOe);

  // R9
  write_hides_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!burstStep && bankOn && !chipEnN && !writeN) |=> ##1 !dataOe);

  // R10
  bank_off_echo_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!burstStep && !bankOn) |=> ##1 !echoOe);

  // R10
  idle_keeps_echo_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!burstStep && bankOn && chipEnN) |=> ##1 echoOe);

endmodule

// File: tb/test_lateWriteSram.sv
module test_lateWriteSram;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int DATA_W = LANES * LANE_W;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic burstStep = 1'b0, chipEnN = 1'b1, bankSelA = 1'b1, bankSelB = 1'b0;
  logic bankSelAHigh = 1'b1, bankSelBHigh = 1'b0, writeN = 1'b1, xorOrder = 1'b0;
  logic [LANES-1:0] laneWrN = '1;
  logic [DATA_W-1:0] dataIn = '0;
  logic [DATA_W-1:0] dataOut;
  logic dataOe, echoOe;

  int checks = 0;
  int fails = 0;

  // reference model state
  logic [DATA_W-1:0] refMem [1 << ADDR_W];
  logic [1:0] mOp = 2'd0;
  logic [ADDR_W-1:0] mAddr = '0, mBase = '0, mWr2A = '0;
  logic [1:0] mCnt = '0;
  logic [LANES-1:0] mMask = '0, mWr2M = '0;
  logic mWr2V = 1'b0;
  logic [DATA_W-1:0] pend1 = '0, pend2 = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lateWriteSram #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_lateWriteSram (
    .clk, .rstN, .addr, .burstStep, .chipEnN, .bankSelA, .bankSelB,
    .bankSelAHigh, .bankSelBHigh, .writeN, .laneWrN, .xorOrder,
    .dataIn, .dataOut, .dataOe, .echoOe
  );

  task automatic check(input string tag, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one clock: inputs applied at a negedge, outputs checked at the next negedge
  task automatic step(input logic adv, input logic c1n, input logic sa, input logic sb,
                      input logic wn, input logic [LANES-1:0] bwn, input logic [ADDR_W-1:0] a,
                      input logic [DATA_W-1:0] wd, input string tag);
    logic expDOe, expEOe, en;
    logic [DATA_W-1:0] expData;
    logic [1:0] low;
    burstStep = adv; chipEnN = c1n; bankSelA = sa; bankSelB = sb;
    writeN = wn; laneWrN = bwn; addr = a;
    dataIn = pend2; pend2 = pend1; pend1 = wd;
    if (mWr2V) begin
      for (int k = 0; k < LANES; k++)
        if (mWr2M[k]) refMem[mWr2A][k*LANE_W +: LANE_W] = dataIn[k*LANE_W +: LANE_W];
    end
    expDOe = (mOp == 2'd2);
    expEOe = (mOp != 2'd0);
    expData = refMem[mAddr];
    mWr2V = (mOp == 2'd3) && (mMask != '0);
    mWr2A = mAddr;
    mWr2M = mMask;
    if (!adv) begin
      en = (sa == bankSelAHigh) && (sb == bankSelBHigh);
      mOp = !en ? 2'd0 : c1n ? 2'd1 : wn ? 2'd2 : 2'd3;
      mBase = a; mAddr = a; mCnt = '0; mMask = ~bwn;
    end else if (mOp >= 2'd2) begin
      mCnt = mCnt + 2'd1;
      low = xorOrder ? (mBase[1:0] ^ mCnt) : (mBase[1:0] + mCnt);
      mAddr = {mBase[ADDR_W-1:2], low};
    end
    @(negedge clk);
    check(tag, "dataOe", {35'd0, dataOe}, {35'd0, expDOe});
    check(tag, "echoOe", {35'd0, echoOe}, {35'd0, expEOe});
    if (expDOe) check(tag, "dataOut", dataOut, expData);
  endtask

  task automatic doRead(input logic [ADDR_W-1:0] a, input string tag);
    step(1'b0, 1'b0, bankSelAHigh, bankSelBHigh, 1'b1, '1, a, '0, tag);
  endtask
  task automatic doWrite(input logic [ADDR_W-1:0] a, input logic [LANES-1:0] bwn,
                         input logic [DATA_W-1:0] wd, input string tag);
    step(1'b0, 1'b0, bankSelAHigh, bankSelBHigh, 1'b0, bwn, a, wd, tag);
  endtask
  task automatic doCont(input logic [DATA_W-1:0] wd, input string tag);
    step(1'b1, 1'b0, bankSelAHigh, bankSelBHigh, 1'b1, '1, '0, wd, tag);
  endtask
  task automatic doIdle(input string tag);
    step(1'b0, 1'b1, bankSelAHigh, bankSelBHigh, 1'b1, '1, '0, '0, tag);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check("R1", "dataOe in reset", {35'd0, dataOe}, '0);
    check("R1", "echoOe in reset", {35'd0, echoOe}, '0);
    rstN = 1'b1;
    doIdle("R1");
  endtask

  task automatic testAlternate();
    for (int i = 0; i < 8; i++) doWrite(8'(i), 4'b0000, 36'(64'h1_0000_0000 * i + 64'hA5A5_0000 + i), "R4");
    for (int i = 0; i < 8; i++) begin
      doRead(8'(i), "R3");
      doWrite(8'(8 + i), 4'b0000, 36'(64'h9_1234_0000 + i), "R9");
    end
    for (int i = 8; i < 16; i++) doRead(8'(i), "R4");
    doIdle("R9");
  endtask

  task automatic testForward();
    doWrite(8'h40, 4'b0000, 36'h1_1111_1111, "R11");
    doWrite(8'h40, 4'b1010, 36'hF_EDCB_A987, "R11");
    doRead(8'h40, "R11");
    doWrite(8'h41, 4'b0000, 36'h2_2222_2222, "R11");
    doRead(8'h41, "R11");
    doIdle("R11");
    doIdle("R11");
  endtask

  task automatic testLanes();
    doWrite(8'h50, 4'b0000, 36'h3_3333_3333, "R6");
    doWrite(8'h50, 4'b1111, 36'hC_CCCC_CCCC, "R6");
    doWrite(8'h50, 4'b1011, 36'h0_0000_0000, "R6");
    doIdle("R6");
    doIdle("R6");
    doRead(8'h50, "R6");
    doIdle("R6");
  endtask

  task automatic testBurstLinear();
    xorOrder = 1'b0;
    doWrite(8'h22, 4'b0000, 36'h0_AAAA_0000, "R7");
    for (int i = 1; i < 5; i++) doCont(36'(64'h0_AAAA_0000 + i), "R7");
    doIdle("R7");
    doRead(8'h22, "R8");
    for (int i = 1; i < 6; i++) doCont('0, "R8");
    // R2: write pins and in-bank enable toggled during continues are ignored
    doRead(8'h21, "R2");
    step(1'b1, 1'b1, bankSelAHigh, bankSelBHigh, 1'b0, 4'b0000, 8'h77, 36'hD_EAD0_0000, "R2");
    step(1'b1, 1'b0, bankSelAHigh, bankSelBHigh, 1'b0, 4'b0000, 8'h77, 36'hD_EAD0_0001, "R2");
    doIdle("R2");
    doIdle("R2");
    doRead(8'h77, "R2");
    doIdle("R2");
  endtask

  task automatic testBurstXor();
    xorOrder = 1'b1;
    doWrite(8'h33, 4'b0000, 36'h0_BBBB_0000, "R8");
    for (int i = 1; i < 4; i++) doCont(36'(64'h0_BBBB_0000 + i), "R8");
    doRead(8'h31, "R8");
    for (int i = 1; i < 5; i++) doCont('0, "R8");
    doIdle("R8");
    xorOrder = 1'b0;
  endtask

  task automatic testDeselect();
    doWrite(8'h60, 4'b0000, 36'h6_6666_6666, "R12");
    doIdle("R10");
    // R12: continue with write pins active while deselected stores nothing
    step(1'b1, 1'b0, bankSelAHigh, bankSelBHigh, 1'b0, 4'b0000, 8'h60, 36'h0, "R12");
    step(1'b1, 1'b0, bankSelAHigh, bankSelBHigh, 1'b0, 4'b0000, 8'h60, 36'h0, "R12");
    // R5/R10: bank deselect by mismatched sense
    step(1'b0, 1'b0, ~bankSelAHigh, bankSelBHigh, 1'b1, '1, 8'h60, '0, "R5");
    step(1'b1, 1'b0, bankSelAHigh, bankSelBHigh, 1'b0, 4'b0000, 8'h60, 36'h0, "R10");
    step(1'b1, 1'b0, bankSelAHigh, bankSelBHigh, 1'b1, '1, 8'h60, '0, "R12");
    // R5: flip the sense straps while idle, then select with the new levels
    bankSelAHigh = 1'b0;
    bankSelBHigh = 1'b1;
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, '1, 8'h60, '0, "R5");
    doRead(8'h60, "R5");
    doRead(8'h60, "R12");
    doIdle("R5");
  endtask

  initial begin
    for (int i = 0; i < (1 << ADDR_W); i++) refMem[i] = '0;
    @(negedge clk);
    testReset();
    testAlternate();
    testForward();
    testLanes();
    testBurstLinear();
    testBurstXor();
    testDeselect();
    repeat (3) doIdle("R9");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d cycles expected=fewer", WATCHDOG);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule